// File: doc/BRIEF.md
# Receive Input Crossbar and Interleaver

This block sits between four data-converter sample streams and a bank of up to four complex downconverters. A 32-bit control word gives each downconverter two 2-bit source selectors, one for its I input and one for its Q input. Each selector picks one of the four converters. A single flag in the same word can force every Q input to zero, which suits real-only reception. The routing is combinational from the converter samples, and it follows a registered copy of the control word.

On the output side, the block takes the 16-bit I/Q results of all channels together with a common strobe. It then serializes the active channels into one 16-bit word stream for a host link. Each word comes with a one-clock valid pulse. The number of active complex channels comes from a 3-bit count field, so a sample period produces 2, 4 or 8 words. The registered control word is reloaded only at frame boundaries. A frame in flight therefore keeps its configuration, and its routing stays fixed until the frame ends.

Top module: `rx_xbar_ilv`

## Requirements
- R1: After reset `out_valid_o` is 0. The held configuration is all zero, so every I and Q downconverter input carries converter 0, and a frame is 2 words long.
- R2: Control bits 2:0 give the active channel count. The values 1, 2 and 4 produce frames of 2, 4 and 8 words.
- R3: A channel count of 0, 3, 5, 6 or 7 is treated as 1 channel, giving 2 words per frame.
- R4: For channel c, the I input is taken from the converter numbered by control bits (5+4c):(4+4c). The Q input is taken from the converter numbered by bits (7+4c):(6+4c). A changed control word appears on the routed outputs one clock after it is presented while no frame is in flight.
- R5: When control bit 3 is 1, every Q input is 0 whatever its selector, and the I inputs are unaffected.
- R6: A strobe sampled while idle starts a frame on the next clock. The words come out on consecutive clocks with valid high, in the order channel 0 I, channel 0 Q, channel 1 I, channel 1 Q, and so on. Valid is low after the last word.
- R7: A control word change during a frame affects neither the routed inputs nor the frame length. It takes effect on the clock after the last word.
- R8: A strobe sampled before the last word of a frame is ignored. A strobe sampled during the last word starts the next frame with no gap.
- R9: Bits 31:20 of the control word have no effect on routing or frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 32 | Routing and channel-count control word |
| adc_i | input | 64 | Four 16-bit converter samples, converter k at bits 16k+15:16k |
| res_i_i | input | 64 | Channel I results, channel c at bits 16c+15:16c |
| res_q_i | input | 64 | Channel Q results, same packing |
| res_stb_i | input | 1 | Results valid, one per sample period |
| ddc_i_o | output | 64 | Routed downconverter I inputs, channel c at bits 16c+15:16c |
| ddc_q_o | output | 64 | Routed downconverter Q inputs, same packing |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 16 | Output word |

## Verification
On every clock, the assertions check the following: the Q outputs are zero whenever the zero flag is held; the held configuration stays frozen while a frame is in flight; a frame always starts the clock after an accepted strobe; the word index stays inside a legal 2, 4 or 8 word frame; and a mid-frame strobe never reloads the frame. The following behaviours are shown only by the bench scenarios: the exact selector-to-converter mapping for each field, the word order and values, the fallback to one channel for illegal counts, the back-to-back frame with no gap, and the fact that the reserved bits are ignored.

// File: rtl/rx_xbar_pkg.sv
package rx_xbar_pkg;
  localparam int unsigned CNT_LSB  = 0;
  localparam int unsigned CNT_W    = 3;
  localparam int unsigned ZERO_BIT = 3;
  localparam int unsigned SEL_LSB  = 4;
endpackage

// File: rtl/rx_xbar_cfg.sv
module rx_xbar_cfg
  import rx_xbar_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SELW   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [31:0]            cfg_i,
  input  logic                   load_i,
  output logic                   zero_o,
  output logic [CNT_W-1:0]       nch_o,
  output logic [NUM_CH*SELW-1:0] isel_o,
  output logic [NUM_CH*SELW-1:0] qsel_o
);
  localparam int unsigned USED_W = SEL_LSB + 2 * NUM_CH * SELW;

  logic [USED_W-1:0] cfg_q;
  logic [CNT_W-1:0]  raw;
  logic              legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i[USED_W-1:0];
  end

  generate
    if (USED_W < 32) begin : g_rsv
      logic unused_rsv;
      assign unused_rsv = ^cfg_i[31:USED_W];
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
      assign isel_o[c*SELW +: SELW] = cfg_q[SEL_LSB + 2*c*SELW +: SELW];
      assign qsel_o[c*SELW +: SELW] = cfg_q[SEL_LSB + 2*c*SELW + SELW +: SELW];
    end
  endgenerate

  assign raw    = cfg_q[CNT_LSB +: CNT_W];
  assign zero_o = cfg_q[ZERO_BIT];
  // power of two, nonzero, within the channel bank
  assign legal  = (raw != '0) && ((raw & (raw - 1'b1)) == '0) && (32'(raw) <= NUM_CH);
  assign nch_o  = legal ? raw : CNT_W'(1);

  // R7
  cfg_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_q));

  // R3
  nch_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(nch_o) == 1);
endmodule

// File: rtl/rx_xbar_route.sv
module rx_xbar_route #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_ADC = 4,
  parameter int unsigned DW      = 16,
  parameter int unsigned SELW    = 2
) (
  input  logic [NUM_ADC*DW-1:0]  adc_i,
  input  logic [NUM_CH*SELW-1:0] isel_i,
  input  logic [NUM_CH*SELW-1:0] qsel_i,
  input  logic                   zero_i,
  output logic [NUM_CH*DW-1:0]   ddc_i_o,
  output logic [NUM_CH*DW-1:0]   ddc_q_o
);
  logic [DW-1:0] adc_a [NUM_ADC];

  generate
    for (genvar k = 0; k < NUM_ADC; k++) begin : g_unpack
      assign adc_a[k] = adc_i[k*DW +: DW];
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ddc_i_o[c*DW +: DW] = adc_a[isel_i[c*SELW +: SELW]];
      assign ddc_q_o[c*DW +: DW] = zero_i ? '0 : adc_a[qsel_i[c*SELW +: SELW]];
    end
  endgenerate
endmodule

// File: rtl/rx_xbar_ser.sv
module rx_xbar_ser
  import rx_xbar_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DW     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH*DW-1:0] res_i_i,
  input  logic [NUM_CH*DW-1:0] res_q_i,
  input  logic                 stb_i,
  input  logic [CNT_W-1:0]     nch_i,
  output logic                 ready_o,
  output logic                 valid_o,
  output logic [DW-1:0]        data_o
);
  localparam int unsigned NWORD = 2 * NUM_CH;
  localparam int unsigned IW    = $clog2(NWORD);
  localparam int unsigned NWW   = IW + 1;

  logic [DW-1:0]  buf_q [NWORD];
  logic           busy_q;
  logic [IW-1:0]  idx_q;
  logic [NWW-1:0] nw_q;
  logic [NWW-1:0] nw_d;
  logic           last;
  logic           accept;

  assign nw_d    = NWW'({nch_i, 1'b0});
  assign last    = busy_q && ({1'b0, idx_q} == nw_q - 1'b1);
  assign ready_o = !busy_q || last;
  assign accept  = stb_i && ready_o;
  assign valid_o = busy_q;
  assign data_o  = buf_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      nw_q   <= NWW'(2);
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      nw_q   <= nw_d;
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) begin
      for (int c = 0; c < NUM_CH; c++) begin
        buf_q[2*c]   <= res_i_i[c*DW +: DW];
        buf_q[2*c+1] <= res_q_i[c*DW +: DW];
      end
    end
  end

  // R6
  frame_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && ready_o) |=> (valid_o && idx_q == '0));

  // R2
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ({1'b0, idx_q} < nw_q));

  // R2
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ($countones(nw_q) == 1 && nw_q >= NWW'(2)));

  // R8
  mid_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last && stb_i) |=> (busy_q && $stable(nw_q)));
endmodule

// File: rtl/rx_xbar_ilv.sv
module rx_xbar_ilv
  import rx_xbar_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_ADC = 4,
  parameter int unsigned DW      = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [31:0]           cfg_i,
  input  logic [NUM_ADC*DW-1:0] adc_i,
  input  logic [NUM_CH*DW-1:0]  res_i_i,
  input  logic [NUM_CH*DW-1:0]  res_q_i,
  input  logic                  res_stb_i,
  output logic [NUM_CH*DW-1:0]  ddc_i_o,
  output logic [NUM_CH*DW-1:0]  ddc_q_o,
  output logic                  out_valid_o,
  output logic [DW-1:0]         out_data_o
);
  localparam int unsigned SELW = $clog2(NUM_ADC);

  logic                   cfg_zero;
  logic [CNT_W-1:0]       cfg_nch;
  logic [NUM_CH*SELW-1:0] cfg_isel;
  logic [NUM_CH*SELW-1:0] cfg_qsel;
  logic                   ser_ready;

  rx_xbar_cfg #(.NUM_CH(NUM_CH), .SELW(SELW)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_i),
    .load_i (ser_ready),
    .zero_o (cfg_zero),
    .nch_o  (cfg_nch),
    .isel_o (cfg_isel),
    .qsel_o (cfg_qsel)
  );

  rx_xbar_route #(.NUM_CH(NUM_CH), .NUM_ADC(NUM_ADC), .DW(DW), .SELW(SELW)) u_route (
    .adc_i   (adc_i),
    .isel_i  (cfg_isel),
    .qsel_i  (cfg_qsel),
    .zero_i  (cfg_zero),
    .ddc_i_o (ddc_i_o),
    .ddc_q_o (ddc_q_o)
  );

  rx_xbar_ser #(.NUM_CH(NUM_CH), .DW(DW)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .res_i_i (res_i_i),
    .res_q_i (res_q_i),
    .stb_i   (res_stb_i),
    .nch_i   (cfg_nch),
    .ready_o (ser_ready),
    .valid_o (out_valid_o),
    .data_o  (out_data_o)
  );

  // R5
  zero_q_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_zero |-> (ddc_q_o == '0));
endmodule

// File: tb/tb_rx_xbar_ilv.sv
`timescale 1ns/1ps
module tb_rx_xbar_ilv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic [63:0] adc = '0;
  logic [63:0] res_i = '0;
  logic [63:0] res_q = '0;
  logic        stb = 1'b0;
  logic [63:0] ddc_i, ddc_q;
  logic        vld;
  logic [15:0] dat;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  rx_xbar_ilv dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .adc_i(adc),
    .res_i_i(res_i), .res_q_i(res_q), .res_stb_i(stb),
    .ddc_i_o(ddc_i), .ddc_q_o(ddc_q), .out_valid_o(vld), .out_data_o(dat)
  );

  function automatic logic [15:0] adc_val(int k);
    return 16'(16'h1000 * (k + 1) + k * 16'h0011);
  endfunction

  // control word: count at 2:0, zero at 3, I sel ch c at 4+4c, Q sel at 6+4c
  function automatic logic [31:0] mk_cfg(int cnt, bit z, logic [7:0] isel, logic [7:0] qsel);
    logic [31:0] w;
    w = 32'(cnt & 7);
    w[3] = z;
    for (int c = 0; c < 4; c++) begin
      w[4+4*c +: 2] = isel[2*c +: 2];
      w[6+4*c +: 2] = qsel[2*c +: 2];
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_route(input string req, input logic [31:0] w);
    for (int c = 0; c < 4; c++) begin
      chk(req, 32'(ddc_i[16*c +: 16]), 32'(adc_val(int'(w[4+4*c +: 2]))));
      chk(req, 32'(ddc_q[16*c +: 16]), w[3] ? 32'h0 : 32'(adc_val(int'(w[6+4*c +: 2]))));
    end
  endtask

  task automatic load_res(input logic [15:0] seed);
    for (int c = 0; c < 4; c++) begin
      res_i[16*c +: 16] = seed + 16'(2*c);
      res_q[16*c +: 16] = seed + 16'(2*c + 1);
    end
  endtask

  // at a negedge while idle: present cfg, wait one clock
  task automatic set_cfg(input logic [31:0] w);
    cfg = w;
    @(negedge clk);
  endtask

  // strobe now, then expect nw words of seed+j, then idle
  task automatic run_frame(input string req, input logic [15:0] seed, input int nw);
    load_res(seed);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    for (int j = 0; j < nw; j++) begin
      chk(req, 32'(vld), 32'h1);
      chk(req, 32'(dat), 32'(seed + 16'(j)));
      @(negedge clk);
    end
    chk(req, 32'(vld), 32'h0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 valid in reset", 32'(vld), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(vld), 32'h0);
    chk_route("R1 route after reset", 32'h0);
    run_frame("R1 default frame", 16'h0100, 2);
  endtask

  task automatic t_route;
    logic [31:0] w;
    w = mk_cfg(4, 1'b0, 8'b00_01_10_11, 8'b10_11_00_01);
    set_cfg(w);
    chk_route("R4 route A", w);
    w = mk_cfg(2, 1'b0, 8'b01_11_00_10, 8'b11_00_10_01);
    set_cfg(w);
    chk_route("R4 route B", w);
  endtask

  task automatic t_zero;
    logic [31:0] w;
    w = mk_cfg(4, 1'b1, 8'b11_10_01_00, 8'b01_01_11_10);
    set_cfg(w);
    chk_route("R5 zero flag", w);
  endtask

  task automatic t_counts;
    set_cfg(mk_cfg(1, 1'b0, 8'h00, 8'h00));
    run_frame("R2 R6 one channel", 16'h2000, 2);
    set_cfg(mk_cfg(2, 1'b0, 8'h00, 8'h00));
    run_frame("R2 R6 two channels", 16'h3000, 4);
    set_cfg(mk_cfg(4, 1'b0, 8'h00, 8'h00));
    run_frame("R2 R6 four channels", 16'h4000, 8);
    set_cfg(mk_cfg(3, 1'b0, 8'h00, 8'h00));
    run_frame("R3 count 3", 16'h5000, 2);
    set_cfg(mk_cfg(0, 1'b0, 8'h00, 8'h00));
    run_frame("R3 count 0", 16'h5100, 2);
    set_cfg(mk_cfg(7, 1'b0, 8'h00, 8'h00));
    run_frame("R3 count 7", 16'h5200, 2);
  endtask

  task automatic t_freeze;
    logic [31:0] w_old, w_new;
    w_old = mk_cfg(4, 1'b0, 8'b00_01_10_11, 8'b11_10_01_00);
    w_new = mk_cfg(1, 1'b1, 8'b01_01_01_01, 8'b10_10_10_10);
    set_cfg(w_old);
    load_res(16'h6000);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    cfg = w_new;
    for (int j = 0; j < 8; j++) begin
      chk("R7 frame kept", 32'(vld), 32'h1);
      chk("R7 frame data", 32'(dat), 32'(16'h6000 + 16'(j)));
      if (j == 3) chk_route("R7 route frozen", w_old);
      @(negedge clk);
    end
    chk("R7 frame end", 32'(vld), 32'h0);
    chk_route("R7 route after frame", w_new);
    @(negedge clk);
  endtask

  task automatic t_ignore;
    set_cfg(mk_cfg(2, 1'b0, 8'h00, 8'h00));
    load_res(16'h7000);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    for (int j = 0; j < 4; j++) begin
      chk("R8 mid strobe ignored", 32'(dat), 32'(16'h7000 + 16'(j)));
      if (j == 1) begin
        load_res(16'h7800);
        stb = 1'b1;
      end else begin
        stb = 1'b0;
      end
      @(negedge clk);
    end
    chk("R8 no extra frame", 32'(vld), 32'h0);
    @(negedge clk);
  endtask

  task automatic t_b2b;
    set_cfg(mk_cfg(1, 1'b0, 8'h00, 8'h00));
    load_res(16'h8000);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    chk("R8 b2b word0", 32'(dat), 32'h8000);
    @(negedge clk);
    chk("R8 b2b word1", 32'(dat), 32'h8001);
    load_res(16'h8800);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    chk("R8 b2b no gap", 32'(vld), 32'h1);
    chk("R8 b2b next word0", 32'(dat), 32'h8800);
    @(negedge clk);
    chk("R8 b2b next word1", 32'(dat), 32'h8801);
    @(negedge clk);
    chk("R8 b2b end", 32'(vld), 32'h0);
    @(negedge clk);
  endtask

  task automatic t_reserved;
    logic [31:0] w;
    w = mk_cfg(2, 1'b0, 8'b10_00_11_01, 8'b00_11_01_10);
    set_cfg(w | 32'hFFF0_0000);
    chk_route("R9 reserved ignored", w);
    run_frame("R9 reserved count", 16'h9000, 4);
  endtask

  initial begin
    adc = {adc_val(3), adc_val(2), adc_val(1), adc_val(0)};
    t_reset();
    t_route();
    t_zero();
    t_counts();
    t_freeze();
    t_ignore();
    t_b2b();
    t_reserved();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule